// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt request lines (eight by default) and decides which one the processor should serve next. Each line is captured on its rising edge into a pending record. A per-level mask set by software hides levels from arbitration without losing them. Among the unmasked pending levels, the lowest index wins: level 0 is the most urgent. The winner's code and a jump address are presented to the processor.

An in-service record lets service routines nest. A pending level raises the processor interrupt only when it outranks every level already in service. Lower levels wait until all higher services have finished. The processor pulses an acknowledge to take the presented level. It pulses end-of-service when a routine returns, which retires the most urgent routine still in service.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset, the interrupt output is low, the level code is 0, the mask is all zeros and the vector is all zeros.
- R2: A request becomes pending on a 0-to-1 transition of its line, sampled at a clock edge. A line held high after its pending bit is consumed does not make it pending again.
- R3: Among pending levels that are not masked, the lowest index wins. Its binary index is shown on `level_o` the cycle after it becomes pending.
- R4: A mask bit of 1 hides that level from arbitration while its pending bit is kept. Clearing the mask bit makes the level eligible again.
- R5: `irq_o` is high only when an eligible level exists and either nothing is in service or the winner's index is strictly lower than the lowest in-service index.
- R6: An acknowledge while `irq_o` is high marks the winner as in service and clears its pending bit. An acknowledge while `irq_o` is low changes nothing.
- R7: An end-of-service pulse clears only the lowest-index in-service bit, letting the next lower-priority pending level through.
- R8: `vector_o` equals the base register, then the 3-bit level code, then two zero bits (base followed by level, shifted left by 2). The base register is loaded by a base write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | NLEV | Interrupt request lines, edge captured |
| mask_we | input | 1 | Load the mask register |
| mask_wdata | input | NLEV | New mask, 1 hides a level |
| base_we | input | 1 | Load the vector base register |
| base_wdata | input | BASEW | New vector base |
| ack_i | input | 1 | Processor takes the presented level |
| eos_i | input | 1 | Processor finished the most urgent routine |
| irq_o | output | 1 | Interrupt request to the processor |
| level_o | output | LW | Code of the winning eligible level |
| vector_o | output | BASEW+LW+2 | Service address for the winning level |

## Verification
The bench steps through every nonzero request pattern, each under a different mask. It checks that the reported level is the lowest unmasked pending index, and that unmasking reveals the hidden levels. A reversed priority scan or a mask applied before capture would report the wrong level or drop requests. Each pattern is then drained by acknowledge and end-of-service pairs, and the number of services must equal the number of requests. A design that re-pends held lines or clears the wrong in-service bit would serve too many or too few. A directed nesting sequence checks pre-emption by a more urgent level, the blocking of a less urgent one, ignored stray acknowledges, and the vector layout.

// File: rtl/prio_nest_intc.sv
module prio_nest_intc #(
  parameter int NLEV  = 8,
  parameter int BASEW = 8,
  localparam int LW   = $clog2(NLEV),
  localparam int VW   = BASEW + LW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLEV-1:0]  req_i,
  input  logic             mask_we,
  input  logic [NLEV-1:0]  mask_wdata,
  input  logic             base_we,
  input  logic [BASEW-1:0] base_wdata,
  input  logic             ack_i,
  input  logic             eos_i,
  output logic             irq_o,
  output logic [LW-1:0]    level_o,
  output logic [VW-1:0]    vector_o
);

  function automatic logic [LW-1:0] first_set(input logic [NLEV-1:0] v);
    logic [LW-1:0] r;
    r = '0;
    for (int i = NLEV - 1; i >= 0; i--)
      if (v[i]) r = LW'(i);
    return r;
  endfunction

  logic [NLEV-1:0]  req_q, pend_q, mask_q, isr_q;
  logic [BASEW-1:0] base_q;

  logic [NLEV-1:0] rise, elig, take_set, eos_clr;
  logic [LW-1:0]   pend_lvl, isr_lvl;
  logic            take;

  assign rise     = req_i & ~req_q;
  assign elig     = pend_q & ~mask_q;
  assign pend_lvl = first_set(elig);
  assign isr_lvl  = first_set(isr_q);

  assign irq_o    = (|elig) && (~|isr_q || pend_lvl < isr_lvl);
  assign level_o  = pend_lvl;
  assign vector_o = {base_q, pend_lvl, 2'b00};

  assign take     = ack_i && irq_o;
  assign take_set = take ? (NLEV'(1) << pend_lvl) : '0;
  assign eos_clr  = (eos_i && |isr_q) ? (NLEV'(1) << isr_lvl) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_q <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~take_set) | rise;
      isr_q  <= (isr_q & ~eos_clr) | take_set;
      if (mask_we) mask_q <= mask_wdata;
      if (base_we) base_q <= base_wdata;
    end
  end

endmodule

// File: rtl/prio_nest_intc_sva.sv
module prio_nest_intc_sva #(
  parameter int NLEV  = 8,
  parameter int BASEW = 8,
  localparam int LW   = $clog2(NLEV),
  localparam int VW   = BASEW + LW + 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack_i,
  input logic            eos_i,
  input logic            irq_o,
  input logic [LW-1:0]   level_o,
  input logic [VW-1:0]   vector_o,
  input logic [NLEV-1:0] pend_q,
  input logic [NLEV-1:0] mask_q,
  input logic [NLEV-1:0] isr_q
);

  logic [NLEV-1:0] upto_win;
  assign upto_win = (NLEV'(2) << level_o) - NLEV'(1);

  a_r3_winner_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_q[level_o] && !mask_q[level_o]));

  a_r5_outranks_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((isr_q & upto_win) == '0));

  a_r6_ack_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o) |=> isr_q[$past(level_o)]);

  a_r6_stray_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eos_i) |=> $stable(isr_q));

  a_r7_eos_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_i && !ack_i && isr_q != '0) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));

  a_r8_vector_layout: assert property (@(posedge clk) disable iff (!rst_n)
    (vector_o[1:0] == 2'b00) && (vector_o[LW+1:2] == level_o));

endmodule

bind prio_nest_intc prio_nest_intc_sva #(.NLEV(NLEV), .BASEW(BASEW)) u_sva (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eos_i(eos_i), .irq_o(irq_o),
  .level_o(level_o), .vector_o(vector_o), .pend_q(pend_q), .mask_q(mask_q),
  .isr_q(isr_q)
);

// File: tb/prio_nest_intc_bench.sv
module prio_nest_intc_bench;
  logic       clk = 0, rst_n = 0;
  logic [7:0] req_i = 0, mask_wdata = 0, base_wdata = 0;
  logic       mask_we = 0, base_we = 0, ack_i = 0, eos_i = 0;
  logic       irq_o;
  logic [2:0] level_o;
  logic [12:0] vector_o;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  prio_nest_intc u_prio_nest_intc (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .base_we(base_we), .base_wdata(base_wdata),
    .ack_i(ack_i), .eos_i(eos_i), .irq_o(irq_o), .level_o(level_o),
    .vector_o(vector_o)
  );

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask
  task automatic pulse_ack; ack_i = 1; tick; ack_i = 0; endtask
  task automatic pulse_eos; eos_i = 1; tick; eos_i = 0; endtask
  task automatic set_mask(input logic [7:0] m);
    mask_we = 1; mask_wdata = m; tick; mask_we = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    chk("R1 irq", irq_o, 0);
    chk("R1 level", level_o, 0);
    chk("R1 vector", vector_o, 0);
    req_i = 8'hFF; tick; req_i = 0;
    chk("R1 mask zero, level0 wins", level_o, 0);
    for (int k = 0; k < 8; k++) begin pulse_ack; pulse_eos; end
    chk("R1 drained", irq_o, 0);

    // sweep all patterns with varied masks
    for (int p = 1; p < 256; p++) begin
      logic [7:0] m, e;
      int served;
      m = 8'((p * 73 + 11) & 8'hFF);
      e = 8'(p) & ~m;
      mask_we = 1; mask_wdata = m; req_i = 8'(p); tick; mask_we = 0;
      chk("R4 masked irq", irq_o, (e != 0) ? 1 : 0);
      if (e != 0) chk("R3 masked winner", level_o, lowest(e));
      set_mask(8'h00);
      chk("R4 unmask winner", level_o, lowest(8'(p)));
      served = 0;
      for (int k = 0; k < 10; k++) begin
        if (irq_o) begin
          pulse_ack;
          chk("R5 lower blocked while serving", irq_o, 0);
          pulse_eos;
          served++;
        end
      end
      chk("R2 R7 one service per edge", served, $countones(8'(p)));
      req_i = 0; tick;
    end

    // nesting and vector
    base_we = 1; base_wdata = 8'hA5; tick; base_we = 0;
    pulse_ack;
    chk("R6 stray ack ignored", irq_o, 0);
    req_i = 8'b0010_0000; tick;
    chk("R3 level five", level_o, 5);
    chk("R8 vector", vector_o, (8'hA5 << 5) | (5 << 2));
    pulse_ack;
    chk("R6 ack consumes", irq_o, 0);
    req_i = 8'b1010_0000; tick;
    chk("R5 level seven waits", irq_o, 0);
    req_i = 8'b1010_0100; tick;
    chk("R5 level two pre-empts", irq_o, 1);
    chk("R5 level two code", level_o, 2);
    pulse_ack;
    chk("R6 level two taken", irq_o, 0);
    pulse_eos;
    chk("R7 level five still in service", irq_o, 0);
    pulse_eos;
    chk("R7 level seven released", irq_o, 1);
    chk("R7 level seven code", level_o, 7);
    chk("R8 vector seven", vector_o, (8'hA5 << 5) | (7 << 2));
    pulse_ack; pulse_eos;
    chk("R2 held lines do not re-pend", irq_o, 0);
    req_i = 0; tick; req_i = 8'b0000_1000; tick;
    chk("R2 new edge pends", irq_o, 1);
    pulse_ack; pulse_eos; req_i = 0; tick;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule